// File: doc/BRIEF.md
# UART FIFO Trigger-Level Controller

This block holds the two byte queues that sit between a UART's host port and its serial shifters. One queue carries bytes from the host to the transmit shifter. The other carries bytes from the receive shifter to the host. An 8-bit control word sets three things: whether the queues are enabled, a self-clearing pointer clear for each queue, and the interrupt thresholds. Receive raises its request by counting stored characters. Transmit raises its request by counting free slots.

Each data path is a valid/ready stream.
- A byte moves only in a cycle where both valid and ready are high.
- An input's ready drops while its queue is full or is being cleared. A byte offered then stays with the sender and is not lost.
- An output's valid is low while its queue is empty or is being cleared.
- A push offered into a full queue, or a pop requested from an empty queue, changes nothing except a sticky error flag.

The shifters appear only as the producer and consumer of these streams.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset the following hold: `ctl_rdata` reads 0x00, both levels are 0, both input readies are 1, both output valids are 0, all four error flags are 0, `rx_irq` is 0 and `tx_irq` is 1.
- R2: Each queue delivers bytes in arrival order. It holds up to 64 bytes, and `*_level` reports the count from 0 to 64. The input ready is 0 while the count is 64.
- R3: A push offered while the queue is full is dropped: the level stays at 64 and the queue's overflow flag sets. A pop requested while the queue is empty is dropped and sets the underflow flag. Both flags stay set until that queue is cleared.
- R4: A control write with bit 0 = 1 and bit 1 = 1 clears the receive queue. Its level and flags go to 0, and the transmit queue is untouched. Read-back bit 1 is 1 for the three cycles that follow the write and then returns to 0 by itself. `rx_in_ready` is 0 during those cycles.
- R5: A control write with bit 0 = 1 and bit 2 = 1 clears the transmit queue in the same way. Read-back bit 2 behaves like bit 1, and the receive queue is untouched.
- R6: A write with bit 0 = 0 starts no clear, even if bits 1 or 2 are set. Levels are unchanged, and read-back bits 2:1 stay 0.
- R7: Read-back bit 3 is always 0, whatever value is written to it.
- R8: Bits 7:6 hold the receive threshold code: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60 characters. With bit 0 = 1, `rx_irq` is 1 exactly while `rx_level` is at or above the threshold.
- R9: Bits 5:4 hold the transmit threshold code: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56 free slots. With bit 0 = 1, `tx_irq` is 1 exactly while 64 minus `tx_level` is at or above the threshold. An empty queue therefore always requests.
- R10: Bits 5:4 take the written value only when `ext_feat_en` is 1. Otherwise they keep their old value.
- R11: With bit 0 = 0 both thresholds are 1. `rx_irq` is then 1 whenever the receive queue holds any byte, and `tx_irq` is 1 whenever the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write value |
| ctl_rdata | output | 8 | Control word read-back |
| ext_feat_en | input | 1 | Allows writes to the transmit threshold code |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue accepts a byte |
| tx_in_data | input | 8 | Transmit byte from host |
| tx_out_valid | output | 1 | Transmit byte available to shifter |
| tx_out_ready | input | 1 | Shifter takes the transmit byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| rx_in_valid | input | 1 | Shifter offers a received byte |
| rx_in_ready | output | 1 | Receive queue accepts a byte |
| rx_in_data | input | 8 | Received byte from shifter |
| rx_out_valid | output | 1 | Received byte available to host |
| rx_out_ready | input | 1 | Host takes the received byte |
| rx_out_data | output | 8 | Oldest received byte |
| tx_level | output | 7 | Bytes in the transmit queue |
| rx_level | output | 7 | Bytes in the receive queue |
| tx_irq | output | 1 | Transmit free-slot request |
| rx_irq | output | 1 | Receive character-count request |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
A corrupted level count shows on `*_level` in the very next cycle. It also moves the interrupt edge away from the threshold, so sweeping every code over every fill level from 0 to 64 exposes it within one push. A pointer fault stays hidden until the queue wraps or drains. The bench therefore fills each queue to 64 and then drains it while comparing every byte. A faulty clear sequencer shows in the read-back bits within three or four cycles of the write.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Receive threshold in stored characters, indexed by the 2-bit code.
  function automatic int unsigned rx_thresh(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  // Transmit threshold in free slots, indexed by the 2-bit code.
  function automatic int unsigned tx_thresh(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uft_byte_fifo.sv
module uft_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] level,
  output logic          ovf,
  output logic          unf
);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, push, pop;

  assign full      = (level == CW'(DEPTH));
  assign empty     = (level == '0);
  assign in_ready  = !full && !clr;
  assign out_valid = !empty && !clr;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = store[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (in_valid && full)   ovf <= 1'b1;
      if (out_ready && empty) unf <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready && !clr) |=> (level == CW'(DEPTH)) && ovf); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf || unf) && !clr) |=> (ovf || !$past(ovf)) && (unf || !$past(unf))); // R3
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0) && !ovf && !unf); // R4

endmodule

// File: rtl/uft_clr_seq.sv
module uft_clr_seq #(
  parameter int RST_CYC = 3,
  localparam int NW     = $clog2(RST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [NW-1:0] remain;

  assign busy = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     remain <= '0;
    else if (start) remain <= NW'(RST_CYC);
    else if (busy)  remain <= remain - 1'b1;
  end

  AST_CLR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (remain == $past(remain) - 1'b1)); // R4
  AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R5

endmodule

// File: rtl/uft_trig.sv
module uft_trig
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic [1:0]    code,
  input  logic          en,
  input  logic [CW-1:0] level,
  output logic          irq
);

  int unsigned thr, amount;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        thr    = en ? tx_thresh(code) : 1;
        amount = DEPTH - int'(level);
      end
    end else begin : g_rx
      always_comb begin
        thr    = en ? rx_thresh(code) : 1;
        amount = int'(level);
      end
    end
  endgenerate

  assign irq = (amount >= thr);

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
  parameter int DEPTH   = 64,
  parameter int RST_CYC = 3,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          ext_feat_en,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [7:0]    tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [7:0]    tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [7:0]    rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [7:0]    rx_out_data,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          tx_ovf,
  output logic          tx_unf,
  output logic          rx_ovf,
  output logic          rx_unf
);

  logic       q_en;
  logic [1:0] rx_code, tx_code;
  logic       rx_busy, tx_busy, rx_go, tx_go;

  // Clear requests count only when the enable bit is set in the same write.
  assign rx_go = ctl_wr && ctl_wdata[0] && ctl_wdata[1];
  assign tx_go = ctl_wr && ctl_wdata[0] && ctl_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en    <= 1'b0;
      rx_code <= 2'b00;
      tx_code <= 2'b00;
    end else if (ctl_wr) begin
      q_en    <= ctl_wdata[0];
      rx_code <= ctl_wdata[7:6];
      if (ext_feat_en) tx_code <= ctl_wdata[5:4];
    end
  end

  assign ctl_rdata = {rx_code, tx_code, 1'b0, tx_busy, rx_busy, q_en};

  uft_clr_seq #(.RST_CYC(RST_CYC)) rx_seq_i (
    .clk(clk), .rst_n(rst_n), .start(rx_go), .busy(rx_busy));
  uft_clr_seq #(.RST_CYC(RST_CYC)) tx_seq_i (
    .clk(clk), .rst_n(rst_n), .start(tx_go), .busy(tx_busy));

  uft_byte_fifo #(.DEPTH(DEPTH), .DW(8)) rx_q_i (
    .clk(clk), .rst_n(rst_n), .clr(rx_busy),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .ovf(rx_ovf), .unf(rx_unf));
  uft_byte_fifo #(.DEPTH(DEPTH), .DW(8)) tx_q_i (
    .clk(clk), .rst_n(rst_n), .clr(tx_busy),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .ovf(tx_ovf), .unf(tx_unf));

  uft_trig #(.DEPTH(DEPTH), .IS_TX(1'b0)) rx_trig_i (
    .code(rx_code), .en(q_en), .level(rx_level), .irq(rx_irq));
  uft_trig #(.DEPTH(DEPTH), .IS_TX(1'b1)) tx_trig_i (
    .code(tx_code), .en(q_en), .level(tx_level), .irq(tx_irq));

  AST_TXCODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ext_feat_en) |=> $stable(tx_code)); // R10
  AST_NO_CLR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[0] && !rx_busy && !tx_busy) |=> !rx_busy && !tx_busy); // R6
  AST_RX_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |-> (rx_irq == (rx_level != '0))); // R11
  AST_TX_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> tx_irq); // R9

endmodule

// File: tb/uart_fifo_trig_tb_top.sv
module uart_fifo_trig_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       ctl_wr = 1'b0, ext_feat_en = 1'b0;
  logic [7:0] ctl_wdata = '0, ctl_rdata;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, rx_in_data = '0, tx_out_data, rx_out_data;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [6:0] tx_level, rx_level;
  logic       tx_irq, rx_irq, tx_ovf, tx_unf, rx_ovf, rx_unf;

  uart_fifo_trig dut_i (.*);

  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_data = d; rx_in_valid = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_in_data = d; tx_in_valid = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic rx_pop();
    rx_out_ready = 1'b1;
    @(negedge clk);
    rx_out_ready = 1'b0;
  endtask

  task automatic tx_pop();
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
  endtask

  function automatic int rx_thr(input int c);
    return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 56 : 60;
  endfunction
  function automatic int tx_thr(input int c);
    return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 32 : 56;
  endfunction

  // Wait out a clear and check that the read-back bit drops on schedule.
  task automatic clr_timing(input string req, input int bitpos);
    for (int k = 0; k < 3; k++) begin
      chk(req, ctl_rdata[bitpos], 1);
      @(negedge clk);
    end
    chk(req, ctl_rdata[bitpos], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 levels", tx_level + rx_level, 0);
    chk("R1 ready", {tx_in_ready, rx_in_ready}, 3);
    chk("R1 valid", {tx_out_valid, rx_out_valid}, 0);
    chk("R1 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
    chk("R1 irqs", {tx_irq, rx_irq}, 2);

    // Receive sweep over all threshold codes
    for (int c = 0; c < 4; c++) begin
      wr(8'(c << 6) | 8'h01);
      chk("R8 code readback", ctl_rdata[7:6], c);
      chk("R8 empty", rx_irq, 0);
      for (int i = 1; i <= 64; i++) begin
        rx_push(8'(i * 5 + c));
        chk("R2 rx level", rx_level, i);
        chk("R8 rx irq", rx_irq, (i >= rx_thr(c)) ? 1 : 0);
      end
      chk("R2 rx full ready", rx_in_ready, 0);
      rx_push(8'hEE);
      chk("R3 rx ovf", rx_ovf, 1);
      chk("R3 rx level held", rx_level, 64);
      if (c == 3) begin
        for (int i = 1; i <= 64; i++) begin
          chk("R2 rx order", rx_out_data, (i * 5 + c) & 255);
          rx_pop();
        end
        rx_pop();
        chk("R3 rx unf", rx_unf, 1);
        chk("R3 rx ovf sticky", rx_ovf, 1);
      end
      for (int i = 0; i < 3; i++) tx_push(8'(i));
      wr(8'(c << 6) | 8'h03);
      chk("R4 rx ready in clr", rx_in_ready, 0);
      clr_timing("R4 bit1", 1);
      chk("R4 rx level", rx_level, 0);
      chk("R4 rx flags", {rx_ovf, rx_unf}, 0);
      chk("R4 tx untouched", tx_level, 3);
      wr(8'h05);
      clr_timing("R5 bit2", 2);
    end

    // Transmit sweep with writes allowed
    ext_feat_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      wr(8'(c << 4) | 8'h01);
      chk("R10 code written", ctl_rdata[5:4], c);
      chk("R9 empty irq", tx_irq, 1);
      for (int i = 1; i <= 64; i++) begin
        tx_push(8'(i ^ (c * 77)));
        chk("R9 tx irq", tx_irq, ((64 - i) >= tx_thr(c)) ? 1 : 0);
      end
      tx_push(8'h00);
      chk("R3 tx ovf", tx_ovf, 1);
      for (int i = 1; i <= 64; i++) begin
        chk("R2 tx order", tx_out_data, (i ^ (c * 77)) & 255);
        tx_pop();
      end
      tx_pop();
      chk("R3 tx unf", tx_unf, 1);
      rx_push(8'h5A);
      wr(8'(c << 4) | 8'h05);
      chk("R5 tx ready in clr", tx_in_ready, 0);
      clr_timing("R5 bit2", 2);
      chk("R5 tx flags", {tx_ovf, tx_unf}, 0);
      chk("R5 rx untouched", rx_level, 1);
      wr(8'h03);
      clr_timing("R4 bit1", 1);
    end

    // R10 locked code
    wr(8'h21);
    ext_feat_en = 1'b0;
    wr(8'h31);
    chk("R10 code kept", ctl_rdata[5:4], 2);
    wr(8'h09);
    chk("R7 reserved bit", ctl_rdata[3], 0);

    // R6 clear requests with enable low
    rx_push(8'h11); rx_push(8'h22); tx_push(8'h33);
    wr(8'h06);
    chk("R6 bits", ctl_rdata[2:1], 0);
    repeat (4) @(negedge clk);
    chk("R6 rx level", rx_level, 2);
    chk("R6 tx level", tx_level, 1);

    // R11 disabled thresholds
    chk("R11 rx irq", rx_irq, 1);
    chk("R11 tx irq", tx_irq, 1);
    rx_pop(); rx_pop();
    chk("R11 rx irq empty", rx_irq, 0);
    for (int i = 0; i < 63; i++) tx_push(8'(i));
    chk("R11 tx irq full", tx_irq, 0);
    tx_pop();
    chk("R11 tx irq one free", tx_irq, 1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule